// File: doc/BRIEF.md
# Configuration Stream Header Stripper

This block sits between a reader that delivers a configuration file one byte at a time and a serializer that loads a device. Only the device payload reaches the serializer. The block first drops a project header of fixed length. It then forwards the payload, starting with the first padding byte. While it forwards, it looks for a four-byte synchronisation word that must come directly after a 0xFF padding byte. When the configured number of payload bits has gone out, it reports completion. It also reports an error when the stream after the header is malformed.

Both edges use a valid/ready byte handshake. While the block forwards, it connects input straight to output through combinational logic, so back-pressure from the serializer reaches the reader in the same cycle. In every other phase it accepts input bytes and drops them. The sync flag is sticky. The done and error flags hold until a synchronous reset, which returns the block to header skipping with every counter cleared.

Top module: `cfg_hdr_strip`

## Requirements
- R1: The first HDR_BYTES accepted bytes after reset are never forwarded. During them `in_ready` is 1 and `out_valid` is 0. A sync word inside the header is not recognised.
- R2: The first byte after the header must be 0xFF. It is then forwarded as the first output byte. If it is any other value, it is dropped, `error` goes high on the next cycle and nothing is forwarded.
- R3: Forwarded bytes leave in arrival order and unchanged: padding, the sync word and the command bytes that follow it.
- R4: `sync_found` is high in the same cycle that the last byte of the sequence 0xAA 0x99 0x55 0x66 is accepted, provided the byte just before 0xAA was 0xFF. It stays high until reset. The same four bytes without a 0xFF directly before them are not a sync.
- R5: Exactly PAYLOAD_BITS/8 bytes are forwarded. `done` is high from the cycle after the last one and stays high. Later input bytes are accepted (`in_ready`=1) and dropped (`out_valid`=0).
- R6: If no sync is seen within SYNC_WINDOW bytes after the header, `error` goes high on the cycle after the last byte of the window. The bytes of the window are forwarded. Afterwards input is accepted and dropped, and `sync_found` stays 0.
- R7: While forwarding, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`, so a stalled byte is held rather than lost.
- R8: A synchronous reset clears `done`, `error` and `sync_found` and restarts header skipping, even in the middle of a stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block takes the input byte this cycle |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Serializer takes the output byte |
| out_data | output | 8 | Output byte |
| sync_found | output | 1 | Sync word seen (sticky) |
| done | output | 1 | Payload length reached |
| error | output | 1 | Malformed stream after the header |

## Verification
Two situations are hard to reach from the ports: a sync that lands on the very last byte of the search window, and a sync-like word that is not directly preceded by padding. The bench runs a small configuration and sweeps the padding length from one byte up to the window limit and one beyond. It also inserts a stray byte between the padding and the sync word, and places a sync word inside the header. Each case runs under three back-pressure patterns, so these boundaries are crossed while the serializer stalls.

// File: rtl/cfgstrip_pkg.sv
package cfgstrip_pkg;
  typedef enum logic [2:0] {
    ST_HDR, ST_HUNT, ST_PASS, ST_DONE, ST_ERR
  } strip_st_t;

  localparam logic [7:0]  PAD_BYTE = 8'hFF;
  localparam logic [31:0] SYNC_PAT = 32'hAA995566;

  // payload length in whole bytes
  function automatic int unsigned bits_to_bytes(input int unsigned nbits);
    return (nbits + 7) / 8;
  endfunction

  // window of the last five bytes, newest in the low byte
  function automatic logic [39:0] push_byte(input logic [39:0] w, input logic [7:0] b);
    return {w[31:0], b};
  endfunction
endpackage

// File: rtl/cfgstrip_cnt.sv
module cfgstrip_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  output logic at_last
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);
  localparam logic [W-1:0] TOP  = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == LAST);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= TOP);
endmodule

// File: rtl/cfgstrip_sync_det.sv
module cfgstrip_sync_det
  import cfgstrip_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       shift,
  input  logic [7:0] byte_in,
  output logic       hit
);
  logic [39:0] win_q;
  logic [39:0] win_nx;

  assign win_nx = push_byte(win_q, byte_in);
  assign hit    = (win_nx == {PAD_BYTE, SYNC_PAT});

  always_ff @(posedge clk) begin
    if (rst)        win_q <= '0;
    else if (shift) win_q <= win_nx;
  end
endmodule

// File: rtl/cfg_hdr_strip.sv
module cfg_hdr_strip
  import cfgstrip_pkg::*;
#(
  parameter int unsigned HDR_BYTES    = 76,
  parameter int unsigned PAYLOAD_BITS = 781216,
  parameter int unsigned SYNC_WINDOW  = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       sync_found,
  output logic       done,
  output logic       error
);
  localparam int unsigned PAY_BYTES = bits_to_bytes(PAYLOAD_BITS);

  strip_st_t st, st_nx;
  logic acc, fwd, first_bad, first_byte;
  logic hdr_last, win_last, pay_last, hit, sync_q;
  logic win_any;

  // first byte after the header: window counter not yet moved
  always_ff @(posedge clk) begin
    if (rst)                       win_any <= 1'b0;
    else if (acc && st == ST_HUNT) win_any <= 1'b1;
  end
  assign first_byte = (st == ST_HUNT) && !win_any;
  assign first_bad  = first_byte && (in_data != PAD_BYTE);

  assign fwd = ((st == ST_HUNT) && !first_bad) || (st == ST_PASS);

  always_comb begin
    unique case (st)
      ST_HUNT: in_ready = first_bad ? 1'b1 : out_ready;
      ST_PASS: in_ready = out_ready;
      default: in_ready = 1'b1;
    endcase
  end

  assign out_valid = in_valid && fwd;
  assign out_data  = in_data;
  assign acc       = in_valid && in_ready;

  cfgstrip_cnt #(.LIMIT(HDR_BYTES)) u_hdr_cnt (
    .clk(clk), .rst(rst), .inc(acc && st == ST_HDR), .at_last(hdr_last));

  cfgstrip_cnt #(.LIMIT(SYNC_WINDOW)) u_win_cnt (
    .clk(clk), .rst(rst), .inc(acc && st == ST_HUNT), .at_last(win_last));

  cfgstrip_cnt #(.LIMIT(PAY_BYTES)) u_pay_cnt (
    .clk(clk), .rst(rst), .inc(acc && fwd), .at_last(pay_last));

  cfgstrip_sync_det u_sync (
    .clk(clk), .rst(rst), .shift(acc && st == ST_HUNT), .byte_in(in_data), .hit(hit));

  always_comb begin
    st_nx = st;
    if (acc) begin
      unique case (st)
        ST_HDR:  if (hdr_last) st_nx = ST_HUNT;
        ST_HUNT: begin
          if (first_bad)     st_nx = ST_ERR;
          else if (hit)      st_nx = ST_PASS;
          else if (win_last) st_nx = ST_ERR;
        end
        ST_PASS: if (pay_last) st_nx = ST_DONE;
        default: st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_HDR;
      sync_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (acc && st == ST_HUNT && hit && !first_bad) sync_q <= 1'b1;
    end
  end

  assign sync_found = sync_q || (acc && st == ST_HUNT && hit);
  assign done       = (st == ST_DONE);
  assign error      = (st == ST_ERR);

  // R1
  hdr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HDR) |-> (!out_valid && in_ready && !sync_found));
  // R4
  sync_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sync_found |=> sync_found);
  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !out_valid && in_ready));
  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    error |=> (error && !out_valid && !sync_found));
  // R7
  pass_hs_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PASS) |-> (in_ready == out_ready && out_valid == in_valid));
  // R8
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!done && !error && !sync_q));
endmodule

// File: tb/cfg_hdr_strip_tb.sv
module cfg_hdr_strip_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HDR = 4;
  localparam int PAYB = 160;
  localparam int PAYN = PAYB / 8;
  localparam int WIN = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00, out_data;
  logic sync_found, done, error;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] strm [64];
  int slen;
  logic [7:0] got [64];
  int ngot, sync_at;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_hdr_strip #(.HDR_BYTES(HDR), .PAYLOAD_BITS(PAYB), .SYNC_WINDOW(WIN)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .sync_found(sync_found), .done(done), .error(error));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic rdy_pat(input int bp, input int c);
    if (bp == 1) return (c % 2) == 0;
    if (bp == 2) return (c % 3) == 1;
    return 1'b1;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    #1;
    chk(!done && !error && !sync_found, "R8 flags clear", {done, error, sync_found}, 0);
    chk(in_ready == 1'b1 && !out_valid, "R8 header state", in_ready, 1);
  endtask

  // header carries a sync word that must be ignored (R1)
  task automatic build(input int pad, input bit bad_first, input bit gap);
    int k;
    strm[0] = 8'hAA; strm[1] = 8'h99; strm[2] = 8'h55; strm[3] = 8'h66;
    k = HDR;
    if (bad_first) begin strm[k] = 8'h00; k++; end
    for (int i = 0; i < pad; i++) begin strm[k] = 8'hFF; k++; end
    if (gap) begin strm[k] = 8'h00; k++; end
    strm[k] = 8'hAA; strm[k+1] = 8'h99; strm[k+2] = 8'h55; strm[k+3] = 8'h66;
    strm[k+4] = 8'h30; strm[k+5] = 8'h00; strm[k+6] = 8'h80; strm[k+7] = 8'h01;
    k += 8;
    while (k < HDR + PAYN + 3) begin strm[k] = 8'((k * 7 + 3) & 8'h7F); k++; end
    slen = k;
  endtask

  task automatic run(input int bp, input int exp_fwd, input int exp_sync,
                     input bit exp_done, input bit exp_err, input int stop_at);
    ngot = 0; sync_at = -1;
    for (int idx = 0; idx < slen && idx < stop_at; idx++) begin
      bit taken = 0;
      while (!taken) begin
        @(negedge clk);
        cyc++;
        in_valid = 1'b1; in_data = strm[idx]; out_ready = rdy_pat(bp, cyc);
        #1;
        if (idx < HDR)
          chk(!out_valid && in_ready && !sync_found, "R1 header dropped", out_valid, 0);
        else if (idx < HDR + exp_fwd)
          chk(out_valid && in_ready == out_ready, "R7 pass handshake", in_ready, out_ready);
        else
          chk(!out_valid && in_ready, "R5/R6 drop after end", out_valid, 0);
        if (out_valid && out_ready) begin got[ngot] = out_data; ngot++; end
        if (sync_found && sync_at < 0 && in_ready) sync_at = idx;
        taken = in_ready;
      end
    end
    @(negedge clk); in_valid = 1'b0; #1;
    if (stop_at < slen) return;
    chk(ngot == exp_fwd, "R5 forwarded count", ngot, exp_fwd);
    for (int i = 0; i < ngot && i < exp_fwd; i++)
      chk(got[i] == strm[HDR + i], "R3 byte order", got[i], strm[HDR + i]);
    chk(sync_at == exp_sync, "R4 sync cycle", sync_at, exp_sync);
    chk(sync_found == (exp_sync >= 0), "R4 sync sticky", sync_found, exp_sync >= 0);
    chk(done == exp_done, "R5 done", done, exp_done);
    chk(error == exp_err, "R6 error", error, exp_err);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int bp = 0; bp < 3; bp++) begin
      // R2 R3 R4 R5: pad length sweep, sync within window
      for (int p = 1; p <= WIN - 4; p++) begin
        build(p, 0, 0); do_reset();
        run(bp, PAYN, HDR + p + 3, 1, 0, 999);
      end
      // R6: sync one byte past the window
      build(WIN - 3, 0, 0); do_reset();
      run(bp, WIN, -1, 0, 1, 999);
      // R2: first byte after the header not padding
      build(3, 1, 0); do_reset();
      run(bp, 0, -1, 0, 1, 999);
      // R4 R6: sync word not adjacent to padding
      build(2, 0, 1); do_reset();
      run(bp, WIN, -1, 0, 1, 999);
      // R8: reset mid-payload, then a clean run
      build(2, 0, 0); do_reset();
      run(bp, PAYN, HDR + 5, 1, 0, HDR + 12);
      do_reset();
      run(bp, PAYN, HDR + 5, 1, 0, 999);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule